// File: doc/BRIEF.md
# Change-of-State Interrupt Digital I/O Register Block

This block is the register file of a digital I/O card. It holds 24 output latches, samples 24 isolated input lines, and drives or reads one byte of bidirectional TTL lines. A host reaches all of it through a small synchronous byte bus: a 4-bit offset, a write strobe with write data, and a read strobe whose data comes back one clock later.

The inputs fall into four groups of eight: three isolated groups and the TTL byte. Each group has its own enable for rising edges and its own enable for falling edges. After the pins pass through a two-flop synchronizer, a qualifying edge on a line sets that line's sticky status bit. A single level interrupt stays high while any status bit is set. Software reads a group's status byte and writes the same value back to the same offset. That write clears exactly those bits, so edges that arrive between the read and the write are not lost.

Top module: `cos_io_ctrl`

## Requirements
- R1: After reset, the output latches, the TTL latch, the TTL direction, the edge enables, all status bits, `irq` and `bus_rdata` are zero.
- R2: Offsets 0x0, 0x1 and 0x2 hold the output latch bytes for lines 0-7, 8-15 and 16-23. A write updates `fet_out` on the clock edge that samples it, and a read returns the stored byte.
- R3: Offset 0x3 holds the TTL output latch, which drives `ttl_out`. Bit 0 of offset 0xC is the TTL direction (1 = output) and drives `ttl_oe`. Both can be read back.
- R4: Offsets 0x4-0x6 return the synchronized isolated inputs and offset 0x7 returns the synchronized TTL pins. A pin change is visible to a read issued two clocks after the pins change.
- R5: Offset 0xE is the edge enable byte and can be read back. Bit g (g = 0..3) enables rising edges and bit g+4 enables falling edges for group g. The groups are, in order, isolated lines 0-7, 8-15, 16-23 and the TTL lines.
- R6: Offsets 0x8+g (g = 0..3, so 0xB is the TTL group) return the status byte of group g. A bit is set only by an edge in a direction that is enabled for its group. The TTL pin value is used whatever the direction.
- R7: A write to offset 0x8+g clears the status bits of group g that are written as 1 and leaves every other status bit unchanged.
- R8: When a qualifying edge and a clear of the same bit fall on the same clock edge, the bit stays set.
- R9: `irq` is high while any status bit is set, and it drops in the cycle after the write that clears the last set bit.
- R10: Reads of the unmapped offsets 0xD and 0xF return 0x00, and writes to them have no effect.
- R11: `bus_rdata` is loaded on the clock edge that samples `bus_rd` and keeps its value while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid one clock after `bus_rd` |
| iso_in | input | 24 | Raw isolated input pins |
| ttl_in | input | 8 | Raw TTL pin values |
| fet_out | output | 24 | Output latch lines |
| ttl_out | output | 8 | TTL output latch |
| ttl_oe | output | 1 | TTL direction, 1 = drive |
| irq | output | 1 | Level change-of-state interrupt |

## Verification
Writes reach `fet_out`, `ttl_out`, `ttl_oe` and the clear logic on the same edge that samples them, so these outputs are due one clock after the strobe. Read data is due one clock after `bus_rd`. A pin change reaches a read two clocks later and sets a status bit (and `irq`) three clocks later. The bench drives every input on the falling edge. It keeps a pin history queue that is three entries deep, so its model follows the same edge-by-edge schedule, and it compares all outputs on each falling edge. Directed reads wait at least four clocks after a pin change. The same-edge collision case is timed to fall exactly on the third edge.

// File: rtl/cos_io_pkg.sv
package cos_io_pkg;
   localparam int unsigned BYTE_W    = 8;
   localparam int unsigned ADDR_W    = 4;
   localparam int unsigned N_ISO_GRP = 3;
   localparam int unsigned N_GRP     = N_ISO_GRP + 1;
   localparam int unsigned ISO_W     = N_ISO_GRP * BYTE_W;
   localparam int unsigned STAT_W    = N_GRP * BYTE_W;
   localparam int unsigned EN_W      = 2 * N_GRP;

   // byte offsets on the register bus
   localparam int OFS_FET0    = 0;
   localparam int OFS_TTL_OUT = OFS_FET0 + N_ISO_GRP;
   localparam int OFS_ISO0    = 4;
   localparam int OFS_TTL_IN  = OFS_ISO0 + N_ISO_GRP;
   localparam int OFS_STAT0   = 8;
   localparam int OFS_CTRL    = OFS_STAT0 + N_GRP;
   localparam int OFS_EN      = 14;
endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= '0;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/cos_edge_grp.sv
module cos_edge_grp #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] cur,
   input  logic         rise_en,
   input  logic         fall_en,
   input  logic         clr_we,
   input  logic [W-1:0] clr_mask,
   output logic [W-1:0] stat
);
   logic [W-1:0] prev_q;
   logic [W-1:0] hit;
   logic [W-1:0] clr;

   assign hit = ({W{rise_en}} & cur & ~prev_q) | ({W{fall_en}} & ~cur & prev_q);
   assign clr = clr_we ? clr_mask : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         stat   <= '0;
      end else begin
         prev_q <= cur;
         // a new edge overrides a clear of the same bit
         stat   <= (stat & ~clr) | hit;
      end
   end
endmodule

// File: rtl/cos_io_ctrl.sv
module cos_io_ctrl
   import cos_io_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_wr,
   input  logic [BYTE_W-1:0]   bus_wdata,
   input  logic                bus_rd,
   output logic [BYTE_W-1:0]   bus_rdata,
   input  logic [ISO_W-1:0]    iso_in,
   input  logic [BYTE_W-1:0]   ttl_in,
   output logic [ISO_W-1:0]    fet_out,
   output logic [BYTE_W-1:0]   ttl_out,
   output logic                ttl_oe,
   output logic                irq
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("cos_io_ctrl: SYNC_STAGES must be at least 2");
   end
   if (EN_W != BYTE_W) begin : g_bad_en
      $error("cos_io_ctrl: enable register must fill one byte");
   end

   logic [ISO_W-1:0]  fet_q;
   logic [BYTE_W-1:0] ttl_o_q;
   logic              dir_q;
   logic [EN_W-1:0]   en_q;
   logic [STAT_W-1:0] stat_q;
   logic [STAT_W-1:0] pins_s;
   logic [BYTE_W-1:0] rd_mux;
   int                adr;

   assign adr = int'(bus_addr);

   cos_sync #(.W(STAT_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({ttl_in, iso_in}), .q(pins_s));

   for (genvar g = 0; g < N_GRP; g++) begin : g_grp
      cos_edge_grp #(.W(BYTE_W)) u_edge (
         .clk      (clk),
         .rst_n    (rst_n),
         .cur      (pins_s[g*BYTE_W +: BYTE_W]),
         .rise_en  (en_q[g]),
         .fall_en  (en_q[N_GRP+g]),
         .clr_we   (bus_wr && (adr == OFS_STAT0 + g)),
         .clr_mask (bus_wdata),
         .stat     (stat_q[g*BYTE_W +: BYTE_W])
      );
   end

   for (genvar b = 0; b < N_ISO_GRP; b++) begin : g_fet
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                               fet_q[b*BYTE_W +: BYTE_W] <= '0;
         else if (bus_wr && adr == OFS_FET0 + b)   fet_q[b*BYTE_W +: BYTE_W] <= bus_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ttl_o_q <= '0;
         dir_q   <= 1'b0;
         en_q    <= '0;
      end else if (bus_wr) begin
         if (adr == OFS_TTL_OUT) ttl_o_q <= bus_wdata;
         if (adr == OFS_CTRL)    dir_q   <= bus_wdata[0];
         if (adr == OFS_EN)      en_q    <= bus_wdata[EN_W-1:0];
      end
   end

   always_comb begin
      rd_mux = '0;
      for (int b = 0; b < N_ISO_GRP; b++) begin
         if (adr == OFS_FET0 + b) rd_mux = fet_q[b*BYTE_W +: BYTE_W];
         if (adr == OFS_ISO0 + b) rd_mux = pins_s[b*BYTE_W +: BYTE_W];
      end
      for (int g = 0; g < N_GRP; g++) begin
         if (adr == OFS_STAT0 + g) rd_mux = stat_q[g*BYTE_W +: BYTE_W];
      end
      if (adr == OFS_TTL_OUT) rd_mux = ttl_o_q;
      if (adr == OFS_TTL_IN)  rd_mux = pins_s[ISO_W +: BYTE_W];
      if (adr == OFS_CTRL)    rd_mux = {{(BYTE_W-1){1'b0}}, dir_q};
      if (adr == OFS_EN)      rd_mux = en_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_mux;
   end

   assign fet_out = fet_q;
   assign ttl_out = ttl_o_q;
   assign ttl_oe  = dir_q;
   assign irq     = |stat_q;
endmodule

// File: rtl/cos_io_ctrl_chk.sv
module cos_io_ctrl_chk
   import cos_io_pkg::*;
(
   input logic                clk,
   input logic                rst_n,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic                bus_wr,
   input logic [BYTE_W-1:0]   bus_wdata,
   input logic                bus_rd,
   input logic [BYTE_W-1:0]   bus_rdata,
   input logic [ISO_W-1:0]    fet_out,
   input logic                ttl_oe,
   input logic                irq,
   input logic [EN_W-1:0]     en_q,
   input logic [STAT_W-1:0]   stat_q
);
   p_fet_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 4'h0) |=> fet_out[7:0] == $past(bus_wdata));

   p_dir_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 4'hC) |=> ttl_oe == $past(bus_wdata[0]));

   p_no_set_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q == '0) |=> (stat_q & ~$past(stat_q)) == '0);

   p_irq_falls_on_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past(bus_wr));

   p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && (bus_addr == 4'hD || bus_addr == 4'hF)) |=> bus_rdata == '0);

   p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));
endmodule

bind cos_io_ctrl cos_io_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
   .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
   .fet_out(fet_out), .ttl_oe(ttl_oe), .irq(irq), .en_q(en_q), .stat_q(stat_q));

// File: tb/cos_io_ctrl_tb_top.sv
`timescale 1ns/1ps
module cos_io_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_rdata;
   logic [23:0] iso_in = '0;
   logic [7:0]  ttl_in = '0;
   logic [23:0] fet_out;
   logic [7:0]  ttl_out;
   logic        ttl_oe;
   logic        irq;

   int n_vec = 0;
   int n_bad = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;  // 50 MHz

   cos_io_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .iso_in(iso_in), .ttl_in(ttl_in), .fet_out(fet_out), .ttl_out(ttl_out),
      .ttl_oe(ttl_oe), .irq(irq));

   // ---------------- behavioural reference model ----------------
   logic [23:0] m_fet;
   logic [7:0]  m_ttlo, m_en, m_rd;
   logic        m_dir;
   logic [31:0] m_st;
   logic [31:0] hist [$];

   function automatic logic [7:0] ref_read(input int a, input logic [31:0] s2);
      if (a <= 2)             return m_fet[a*8 +: 8];
      if (a == 3)             return m_ttlo;
      if (a >= 4 && a <= 7)   return s2[(a-4)*8 +: 8];
      if (a >= 8 && a <= 11)  return m_st[(a-8)*8 +: 8];
      if (a == 12)            return {7'd0, m_dir};
      if (a == 14)            return m_en;
      return 8'h00;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      logic [31:0] s2, s3, set, clr;
      int a;
      if (!rst_n) begin
         m_fet = '0; m_ttlo = '0; m_en = '0; m_rd = '0; m_dir = 1'b0; m_st = '0;
         hist = '{32'd0, 32'd0, 32'd0};
      end else begin
         a = int'(bus_addr);
         s2 = hist[1];
         s3 = hist[2];
         if (bus_rd) m_rd = ref_read(a, s2);
         set = '0;
         clr = '0;
         for (int g = 0; g < 4; g++) begin
            if (m_en[g])   set[g*8 +: 8] = set[g*8 +: 8] | (s2[g*8 +: 8] & ~s3[g*8 +: 8]);
            if (m_en[g+4]) set[g*8 +: 8] = set[g*8 +: 8] | (~s2[g*8 +: 8] & s3[g*8 +: 8]);
         end
         if (bus_wr && a >= 8 && a <= 11) clr[(a-8)*8 +: 8] = bus_wdata;
         m_st = (m_st & ~clr) | set;
         if (bus_wr) begin
            if (a <= 2)  m_fet[a*8 +: 8] = bus_wdata;
            if (a == 3)  m_ttlo = bus_wdata;
            if (a == 12) m_dir = bus_wdata[0];
            if (a == 14) m_en = bus_wdata;
         end
         hist.push_front({ttl_in, iso_in});
         void'(hist.pop_back());
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
      end
   endtask

   // compare every output with the model on each falling edge
   always @(negedge clk) begin
      if (!done) begin
         chk("R2 fet_out", fet_out, m_fet);
         chk("R3 ttl_out", ttl_out, m_ttlo);
         chk("R3 ttl_oe", ttl_oe, m_dir);
         chk("R9 irq", irq, m_st != 0);
         chk("R11 bus_rdata", bus_rdata, m_rd);
      end
   end

   task automatic summary();
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !done) begin
         n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         summary();
      end
   end

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input string tag);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      chk(tag, bus_rdata, exp);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1 reset state
      chk("R1 fet_out", fet_out, 24'h0);
      chk("R1 ttl_oe", ttl_oe, 1'b0);
      chk("R1 irq", irq, 1'b0);
      chk("R1 rdata", bus_rdata, 8'h00);
      rd_chk(4'hE, 8'h00, "R1 enable");
      rd_chk(4'hB, 8'h00, "R1 status");

      // R2 output latches
      wr(4'h0, 8'h11); wr(4'h1, 8'h22); wr(4'h2, 8'h33);
      chk("R2 fet word", fet_out, 24'h332211);
      rd_chk(4'h1, 8'h22, "R2 readback");

      // R3 TTL latch and direction
      wr(4'h3, 8'hA5); wr(4'hC, 8'h01);
      chk("R3 ttl_out", ttl_out, 8'hA5);
      chk("R3 ttl_oe", ttl_oe, 1'b1);
      rd_chk(4'hC, 8'h01, "R3 ctrl readback");

      // R4 synchronized inputs (enables still zero: R6 no status)
      iso_in = 24'hABCDEF;
      idle(4);
      rd_chk(4'h4, 8'hEF, "R4 iso byte0");
      rd_chk(4'h6, 8'hAB, "R4 iso byte2");
      rd_chk(4'h8, 8'h00, "R6 disabled no status");

      // R5 enables: rise grp0, fall grp1
      wr(4'hE, 8'h21);
      rd_chk(4'hE, 8'h21, "R5 enable readback");
      iso_in = 24'hFFC0E0;
      idle(4);
      iso_in = 24'hFFC0E3;
      idle(4);
      rd_chk(4'h8, 8'h03, "R6 grp0 rising");
      rd_chk(4'h9, 8'h0D, "R6 grp1 falling");
      rd_chk(4'hA, 8'h00, "R6 grp2 not enabled");
      chk("R9 irq set", irq, 1'b1);

      // R7 partial clear
      wr(4'h9, 8'h05);
      rd_chk(4'h9, 8'h08, "R7 partial clear");
      rd_chk(4'h8, 8'h03, "R7 other group kept");
      wr(4'h8, 8'h03);
      chk("R9 irq still set", irq, 1'b1);
      wr(4'h9, 8'h08);
      chk("R9 irq dropped", irq, 1'b0);

      // TTL group, both edges
      wr(4'hE, 8'h88);
      ttl_in = 8'h0F;
      idle(4);
      rd_chk(4'hB, 8'h0F, "R6 ttl rising");
      ttl_in = 8'h0C;
      idle(4);
      rd_chk(4'hB, 8'h0F, "R6 ttl sticky");
      wr(4'hB, 8'hFF);
      ttl_in = 8'h00;
      idle(4);
      rd_chk(4'hB, 8'h0C, "R6 ttl falling");

      // R8 edge coincides with clear of the same bit
      ttl_in = 8'h04;
      idle(2);
      wr(4'hB, 8'h04);
      rd_chk(4'hB, 8'h0C, "R8 edge beats clear");
      rd_chk(4'h7, 8'h04, "R4 ttl pins");

      // R10 unmapped offsets
      wr(4'hD, 8'hFF); wr(4'hF, 8'hFF);
      rd_chk(4'hD, 8'h00, "R10 offset D");
      rd_chk(4'hF, 8'h00, "R10 offset F");
      chk("R10 fet untouched", fet_out, 24'h332211);

      // R11 hold while not reading
      rd_chk(4'h0, 8'h11, "R11 read");
      wr(4'h0, 8'h99);
      idle(2);
      chk("R11 rdata held", bus_rdata, 8'h11);

      idle(2);
      summary();
   end
endmodule